// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Dead Time

This block drives the four power switches of one full bridge: a high-side and a low-side gate for each of its two legs. Its inputs are a bridge enable, two direction bits and a chop request from the constant-off-time current regulator. It decodes the inputs into one of four conduction modes: lower-path brake, forward, reverse and upper-path brake. When enable is low it holds the bridge fully off. Each leg runs its own sequencer. When a leg must change what it drives, the sequencer first releases both gates of that leg, waits a programmable number of clock cycles and only then turns on the new switch.

A chop request is active while the regulator's off-time monostable runs. During forward or reverse drive it applies slow decay. The grounded leg drops its low-side switch, waits one dead time and then closes its own high-side switch, so the load current recirculates through the upper path with synchronous rectification. When the request ends, that high-side switch opens, a second dead time passes and the low side closes again. A high-impedance flag reports when both legs have settled fully off.

Top module: `hbridge_gate_ctl`

## Requirements
- R1: With `en_i` low, all four gates are off from the next clock edge on. `hiz_o` is high exactly when both legs are settled off, which happens `DEAD_CYC` cycles after a conducting leg is released.
- R2: With `en_i` high and both direction bits low, both low-side gates conduct (lower-path brake) and no high-side gate is on.
- R3: With `dir_a_i`=1 and `dir_b_i`=0 (forward), leg 0 (bit 0 of each gate vector) has its high side on and leg 1 has its low side on.
- R4: With `dir_a_i`=0 and `dir_b_i`=1 (reverse), leg 0 has its low side on and leg 1 has its high side on.
- R5: With both direction bits high, both high-side gates conduct (upper-path brake) and no low-side gate is on.
- R6: In forward, a high `chop_i` turns leg 1's low side off at the next edge. After `DEAD_CYC` cycles with leg 1 fully off, leg 1's high side turns on. When `chop_i` falls, the same sequence runs in reverse, ending with the low side back on.
- R7: In reverse, `chop_i` runs the same off-phase sequence as R6 on leg 0.
- R8: `chop_i` has no effect in either brake mode or while disabled.
- R9: No leg ever has its high and low gates on in the same cycle.
- R10: A leg that leaves a conducting state keeps both gates off for at least `DEAD_CYC` cycles before either gate turns on, even if the target reverts during that wait. A leg that is settled off turns on at the next edge. A leg whose target is unchanged is not interrupted.
- R11: During reset all gates are off and `hiz_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Bridge enable; low forces all switches off |
| dir_a_i | input | 1 | Direction bit for leg 0 |
| dir_b_i | input | 1 | Direction bit for leg 1 |
| chop_i | input | 1 | Off-time request from the current regulator |
| gate_hs_o | output | 2 | High-side gate enables, bit i = leg i |
| gate_ls_o | output | 2 | Low-side gate enables, bit i = leg i |
| hiz_o | output | 1 | Both legs settled off (outputs floating) |

## Verification
The bench walks every mode transition cycle by cycle and counts the exact length of each dead-time gap. A sequencer that skipped or shortened the gap would show a high and a low gate turning on too early in the same leg. The bench reverts the target in the middle of a dead time; a design that let the leg return at once to its old switch would end the gap early. It also applies chop in both brake modes and while disabled, where a design that obeyed it would break the brake path. It checks that a leg with an unchanged target keeps conducting through a direction change, and that `hiz_o` rises only after the release dead time and not as soon as enable drops.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [1:0] {LEG_OFF, LEG_HI, LEG_LO, LEG_DEAD} leg_st_e;
  typedef enum logic [1:0] {TGT_OFF, TGT_HI, TGT_LO} leg_tgt_e;
  localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/hbg_target_map.sv
module hbg_target_map
  import hbg_pkg::*;
(
  input  logic     en_i,
  input  logic     dir_a_i,
  input  logic     dir_b_i,
  input  logic     chop_i,
  output leg_tgt_e tgt_o [NUM_LEGS]
);
  always_comb begin
    tgt_o[0] = TGT_OFF;
    tgt_o[1] = TGT_OFF;
    if (en_i) begin
      unique case ({dir_a_i, dir_b_i})
        2'b00: begin tgt_o[0] = TGT_LO; tgt_o[1] = TGT_LO; end
        2'b10: begin
          tgt_o[0] = TGT_HI;
          tgt_o[1] = chop_i ? TGT_HI : TGT_LO;   // slow decay on grounded leg
        end
        2'b01: begin
          tgt_o[0] = chop_i ? TGT_HI : TGT_LO;
          tgt_o[1] = TGT_HI;
        end
        default: begin tgt_o[0] = TGT_HI; tgt_o[1] = TGT_HI; end
      endcase
    end
  end
endmodule

// File: rtl/hbg_leg_seq.sv
module hbg_leg_seq
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  leg_tgt_e tgt_i,
  output logic     hs_o,
  output logic     ls_o,
  output logic     idle_o
);
  localparam int unsigned CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEAD_CYC - 1);

  leg_st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic leg_st_e settle(input leg_tgt_e t);
    unique case (t)
      TGT_HI:  return LEG_HI;
      TGT_LO:  return LEG_LO;
      default: return LEG_OFF;
    endcase
  endfunction

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      LEG_OFF: st_d = settle(tgt_i);
      LEG_HI: if (tgt_i != TGT_HI) begin st_d = LEG_DEAD; cnt_d = '0; end
      LEG_LO: if (tgt_i != TGT_LO) begin st_d = LEG_DEAD; cnt_d = '0; end
      default: begin
        if (cnt_q == CNT_LAST) st_d = settle(tgt_i);
        else                   cnt_d = cnt_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LEG_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign hs_o   = (st_q == LEG_HI);
  assign ls_o   = (st_q == LEG_LO);
  assign idle_o = (st_q == LEG_OFF);
endmodule

// File: rtl/hbridge_gate_ctl.sv
module hbridge_gate_ctl
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       dir_a_i,
  input  logic       dir_b_i,
  input  logic       chop_i,
  output logic [1:0] gate_hs_o,
  output logic [1:0] gate_ls_o,
  output logic       hiz_o
);
  leg_tgt_e                tgt [NUM_LEGS];
  logic [NUM_LEGS-1:0]     idle;

  hbg_target_map u_map (
    .en_i   (en_i),
    .dir_a_i(dir_a_i),
    .dir_b_i(dir_b_i),
    .chop_i (chop_i),
    .tgt_o  (tgt)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hbg_leg_seq #(.DEAD_CYC(DEAD_CYC)) u_seq (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tgt_i (tgt[g]),
      .hs_o  (gate_hs_o[g]),
      .ls_o  (gate_ls_o[g]),
      .idle_o(idle[g])
    );
  end

  assign hiz_o = &idle;
endmodule

// File: rtl/hbg_gate_chk.sv
module hbg_gate_chk #(
  parameter int unsigned DEAD_CYC = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       dir_a_i,
  input logic       dir_b_i,
  input logic       chop_i,
  input logic [1:0] gate_hs_o,
  input logic [1:0] gate_ls_o,
  input logic       hiz_o
);
  localparam int unsigned GW = $clog2(DEAD_CYC + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(DEAD_CYC);

  for (genvar i = 0; i < 2; i++) begin : g_leg
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         gap_q <= GAP_MAX;
      else if (gate_hs_o[i] || gate_ls_o[i]) gap_q <= '0;
      else if (gap_q != GAP_MAX)           gap_q <= gap_q + 1'b1;
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(gate_hs_o[i] && gate_ls_o[i])); // R9
    AST_DEAD_GAP_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gate_hs_o[i]) |-> gap_q >= GAP_MAX); // R10
    AST_DEAD_GAP_LS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gate_ls_o[i]) |-> gap_q >= GAP_MAX); // R10
  end

  AST_DISABLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (gate_hs_o == 2'b00 && gate_ls_o == 2'b00)); // R1
  AST_HIZ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_o |-> (gate_hs_o == 2'b00 && gate_ls_o == 2'b00)); // R1
  AST_LOWER_BRAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !dir_a_i && !dir_b_i) |=> gate_hs_o == 2'b00); // R2
  AST_FWD_LEG0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dir_a_i && !dir_b_i) |=> !gate_ls_o[0]); // R3
  AST_REV_LEG1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !dir_a_i && dir_b_i) |=> !gate_ls_o[1]); // R4
  AST_UPPER_BRAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dir_a_i && dir_b_i) |=> gate_ls_o == 2'b00); // R5
  AST_FWD_CHOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dir_a_i && !dir_b_i && chop_i) |=> !gate_ls_o[1]); // R6
  AST_REV_CHOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !dir_a_i && dir_b_i && chop_i) |=> !gate_ls_o[0]); // R7
endmodule

bind hbridge_gate_ctl hbg_gate_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (.*);

// File: tb/sim_hbridge_gate_ctl.sv
`timescale 1ns/1ps
module sim_hbridge_gate_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int DT = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, da = 1'b0, db = 1'b0, chop = 1'b0;
  logic [1:0] hs, ls;
  logic hiz;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [4:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_gate_ctl #(.DEAD_CYC(DT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .dir_a_i(da), .dir_b_i(db),
    .chop_i(chop), .gate_hs_o(hs), .gate_ls_o(ls), .hiz_o(hiz)
  );

  task automatic cmp(input logic [4:0] act, input logic [4:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act hs=%b ls=%b hiz=%b exp hs=%b ls=%b hiz=%b",
               tag, act[4:3], act[2:1], act[0], exp[4:3], exp[2:1], exp[0]);
    end
  endtask

  // monitor: compares after each active edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) cmp({hs, ls, hiz}, exp_q.pop_front(), tag_q.pop_front());
  end

  // driver: inputs at negedge, expectation for the following edge
  task automatic step(input logic e, a, b, c, input logic [1:0] xh, xl,
                      input logic xz, input string tag);
    @(negedge clk);
    en = e; da = a; db = b; chop = c;
    exp_q.push_back({xh, xl, xz});
    tag_q.push_back(tag);
  endtask

  task automatic stepn(input int n, input logic e, a, b, c, input logic [1:0] xh, xl,
                       input logic xz, input string tag);
    for (int k = 0; k < n; k++) step(e, a, b, c, xh, xl, xz, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act hung exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2);
    cmp({hs, ls, hiz}, 5'b00_00_1, "R11 reset");
    @(negedge clk); rst_ni = 1'b1;

    stepn(2, 0,0,0,0, 2'b00, 2'b00, 1'b1, "R1 disabled");
    stepn(3, 1,0,0,0, 2'b00, 2'b11, 1'b0, "R2 lower brake from off");
    // forward: leg0 LO->HI needs dead time, leg1 keeps LO
    stepn(DT, 1,1,0,0, 2'b00, 2'b10, 1'b0, "R10 fwd dead leg0");
    stepn(2,  1,1,0,0, 2'b01, 2'b10, 1'b0, "R3 forward");
    // chop in forward
    stepn(DT, 1,1,0,1, 2'b01, 2'b00, 1'b0, "R6 chop dead");
    stepn(2,  1,1,0,1, 2'b11, 2'b00, 1'b0, "R6 sync rect");
    stepn(DT, 1,1,0,0, 2'b01, 2'b00, 1'b0, "R6 chop end dead");
    stepn(1,  1,1,0,0, 2'b01, 2'b10, 1'b0, "R6 low side back");
    // reverse: both legs change
    stepn(DT, 1,0,1,0, 2'b00, 2'b00, 1'b0, "R10 rev dead both");
    stepn(2,  1,0,1,0, 2'b10, 2'b01, 1'b0, "R4 reverse");
    // chop in reverse
    stepn(DT, 1,0,1,1, 2'b10, 2'b00, 1'b0, "R7 chop dead");
    stepn(1,  1,0,1,1, 2'b11, 2'b00, 1'b0, "R7 sync rect");
    stepn(DT, 1,0,1,0, 2'b10, 2'b00, 1'b0, "R7 chop end dead");
    stepn(1,  1,0,1,0, 2'b10, 2'b01, 1'b0, "R7 low side back");
    // upper brake, chop ignored
    stepn(DT, 1,1,1,0, 2'b10, 2'b00, 1'b0, "R10 upper dead leg0");
    stepn(1,  1,1,1,0, 2'b11, 2'b00, 1'b0, "R5 upper brake");
    stepn(3,  1,1,1,1, 2'b11, 2'b00, 1'b0, "R8 chop in upper brake");
    // disable: gates off at once, hiz after dead time
    stepn(DT, 0,1,1,0, 2'b00, 2'b00, 1'b0, "R1 release dead");
    stepn(1,  0,1,1,0, 2'b00, 2'b00, 1'b1, "R1 hiz settled");
    stepn(2,  0,1,0,1, 2'b00, 2'b00, 1'b1, "R8 chop while disabled");
    // lower brake with chop
    stepn(3,  1,0,0,1, 2'b00, 2'b11, 1'b0, "R8 chop in lower brake");
    // target reverts mid dead time
    stepn(1,    1,1,0,0, 2'b00, 2'b10, 1'b0, "R10 enter dead");
    stepn(DT-1, 1,0,0,0, 2'b00, 2'b10, 1'b0, "R10 revert keeps gap");
    stepn(1,    1,0,0,0, 2'b00, 2'b11, 1'b0, "R10 gap done");

    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule